// File: doc/BRIEF.md
# Three-Level Fundamental-Frequency Gate Sequencer

This block drives the twelve gates of a three-phase, three-level clamped bridge whose rails are already shaped by an upstream stage. No carrier or pulse-width modulation is used. Each leg walks a fixed six-segment pattern once per fundamental period: two sixths on the high rail, one on the middle, two on the low, one on the middle again. Each leg therefore changes its driven state only four times per period.

The period is given in clock cycles and split into six equal segments. For a 50 Hz output from a 50 MHz clock, program 1,000,000 counts. A new period value is taken only at a period boundary or while the block is idle. At every transition the switch that leaves conduction opens at once. The switch that joins waits for a programmable dead-time count. A 2-bit level code per phase reports which rail the leg drives, or that it is undriven.

Top module: `tl_gate_sequencer`

## Requirements
- R1: While `rst` is high, or in the cycle after any rising edge where `en` was sampled low, every gate bit is 0 and every level code is 2'b11.
- R2: Gate bit `4*p+k` is switch k+1 of phase p, where phase A=0, B=1 and C=2. Phase A, by sixth of the period, has switches 1+2 on in sixths 0 and 1, switches 2+3 in sixth 2, switches 3+4 in sixths 3 and 4, and switches 2+3 in sixth 5.
- R3: Each sixth lasts floor(`period_len`/6) clock cycles, with a minimum of 1. The period is therefore `period_len` rounded down to a multiple of six. Sixth 0 begins at the first rising edge where `en` is sampled high.
- R4: Phases B and C follow the phase A pattern delayed by 2 and 4 sixths. At enable, B starts at the beginning of its sixth 4 (low rail) and C at the beginning of its sixth 2 (middle rail). With zero dead time, the level bus reads 6'b010010 one cycle after enable.
- R5: `period_len` is sampled only while idle and at the last cycle of each period. A change in the middle of a period takes effect from the next period.
- R6: When a leg's target changes, at the next edge the leaving switch opens and the shared switch stays on. The joining switch turns on `dead_cnt` cycles after that. With `dead_cnt`=0, the new state appears at once. `dead_cnt` must be smaller than one sixth.
- R7: The level code of phase p sits at bits [2p+1:2p]. It is 2'b10 for the high rail (switches 1+2), 2'b01 for the middle rail (switches 2+3), 2'b00 for the low rail (switches 3+4), and 2'b11 for anything else.
- R8: In steady operation, each leg enters a new driven level exactly four times in every period.
- R9: Within a leg, switches 1 and 3, switches 2 and 4, and switches 1 and 4 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off and restarts the sequence |
| period_len | input | 24 | Fundamental period in clock cycles |
| dead_cnt | input | 8 | Delay in cycles before a joining switch turns on |
| gate | output | 12 | Gate drives, four per phase |
| level | output | 6 | Rail code, two bits per phase |

## Verification
The hardest case to reach from the ports is a period change that lands in the middle of a period. The new segment length must not appear until the final sixth has run out. The stimulus changes `period_len` at an arbitrary cycle while the block runs, and the cycle model shows exactly where the segment length must switch. Dead-time windows are exercised with a non-zero count and, by re-enabling, with a zero count. Both cases come under the shortest legal segment, where dead time and segment boundaries nearly collide. The three-phase start-up offset is read in the first cycle after enable.

// File: rtl/tl_seq_pkg.sv
package tl_seq_pkg;
    localparam int NPH = 3;
    localparam int SIXTHS = 6;

    typedef enum logic [1:0] {
        LV_LOW  = 2'b00,
        LV_MID  = 2'b01,
        LV_HIGH = 2'b10,
        LV_OPEN = 2'b11
    } level_e;

    typedef logic [3:0] leg_gates_t;

    localparam leg_gates_t G_HIGH = 4'b0011;
    localparam leg_gates_t G_MID  = 4'b0110;
    localparam leg_gates_t G_LOW  = 4'b1100;

    function automatic leg_gates_t sixth_pattern(input logic [2:0] idx);
        leg_gates_t g;
        case (idx)
            3'd0, 3'd1: g = G_HIGH;
            3'd3, 3'd4: g = G_LOW;
            default:    g = G_MID;
        endcase
        return g;
    endfunction

    function automatic logic [2:0] phase_sixth(input logic [2:0] s, input int ph);
        int v;
        v = (int'(s) + SIXTHS * NPH - 2 * ph) % SIXTHS;
        return 3'(v);
    endfunction

    function automatic level_e level_of(input leg_gates_t g);
        level_e l;
        case (g)
            G_HIGH:  l = LV_HIGH;
            G_MID:   l = LV_MID;
            G_LOW:   l = LV_LOW;
            default: l = LV_OPEN;
        endcase
        return l;
    endfunction
endpackage

// File: rtl/tl_seq_timer.sv
module tl_seq_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_len,
    output logic [2:0]       sixth
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] seg_q;
    logic [CNT_W-1:0] tick_q;
    logic [CNT_W-1:0] seg_new;

    always_comb begin
        seg_new = period_len / CNT_W'(6);
        if (seg_new == '0)
            seg_new = ONE;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tick_q <= '0;
            sixth  <= 3'd0;
            seg_q  <= seg_new;
        end else if (tick_q == seg_q - ONE) begin
            tick_q <= '0;
            if (sixth == 3'd5) begin
                sixth <= 3'd0;
                seg_q <= seg_new;
            end else begin
                sixth <= sixth + 3'd1;
            end
        end else begin
            tick_q <= tick_q + ONE;
        end
    end
endmodule

// File: rtl/tl_leg_driver.sv
module tl_leg_driver
    import tl_seq_pkg::*;
#(
    parameter int PH   = 0,
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [2:0]      sixth,
    input  logic [DT_W-1:0] dead_cnt,
    output leg_gates_t      gates
);
    leg_gates_t      target;
    logic            busy_q;
    logic [DT_W-1:0] dcnt_q;

    always_comb target = sixth_pattern(phase_sixth(sixth, PH));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gates  <= '0;
            busy_q <= 1'b0;
            dcnt_q <= '0;
        end else if (busy_q) begin
            if (dcnt_q <= DT_W'(1)) begin
                gates  <= target;
                busy_q <= 1'b0;
            end else begin
                dcnt_q <= dcnt_q - DT_W'(1);
            end
        end else if (gates != target) begin
            if (dead_cnt == '0) begin
                gates <= target;
            end else begin
                gates  <= gates & target;
                busy_q <= 1'b1;
                dcnt_q <= dead_cnt;
            end
        end
    end
endmodule

// File: rtl/tl_gate_sequencer.sv
module tl_gate_sequencer
    import tl_seq_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int DT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CNT_W-1:0]     period_len,
    input  logic [DT_W-1:0]      dead_cnt,
    output logic [4*NPH-1:0]     gate,
    output logic [2*NPH-1:0]     level
);
    logic [2:0] sixth;

    tl_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .en(en),
        .period_len(period_len), .sixth(sixth)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        leg_gates_t lg;
        tl_leg_driver #(.PH(p), .DT_W(DT_W)) u_leg (
            .clk(clk), .rst(rst), .en(en),
            .sixth(sixth), .dead_cnt(dead_cnt), .gates(lg)
        );
        assign gate[4*p +: 4]  = lg;
        assign level[2*p +: 2] = level_of(lg);
    end
endmodule

// File: rtl/tl_gate_sequencer_chk.sv
module tl_gate_sequencer_chk
    import tl_seq_pkg::*;
#(
    parameter int DT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [DT_W-1:0]   dead_cnt,
    input logic [4*NPH-1:0]  gate,
    input logic [2*NPH-1:0]  level
);
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate == '0 && level == '1));

    for (genvar p = 0; p < NPH; p++) begin : g_chk
        assert_interlock_R9: assert property (@(posedge clk) disable iff (rst)
            !(gate[4*p] && gate[4*p+2]) && !(gate[4*p+1] && gate[4*p+3])
            && !(gate[4*p] && gate[4*p+3]));

        assert_dead_gap_R6: assert property (@(posedge clk) disable iff (rst)
            ($past(dead_cnt) != '0 && dead_cnt != '0 && $past(en) && en
             && $past(level[2*p +: 2]) != 2'b11 && level[2*p +: 2] != 2'b11)
            |-> level[2*p +: 2] == $past(level[2*p +: 2]));

        assert_leave_high_R2: assert property (@(posedge clk) disable iff (rst)
            ($past(level[2*p +: 2]) == 2'b10 && level[2*p +: 2] != 2'b10)
            |-> (level[2*p +: 2] == 2'b01 || level[2*p +: 2] == 2'b11));

        assert_leave_low_R2: assert property (@(posedge clk) disable iff (rst)
            ($past(level[2*p +: 2]) == 2'b00 && level[2*p +: 2] != 2'b00)
            |-> (level[2*p +: 2] == 2'b01 || level[2*p +: 2] == 2'b11));
    end
endmodule

bind tl_gate_sequencer tl_gate_sequencer_chk #(.DT_W(DT_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .dead_cnt(dead_cnt),
    .gate(gate), .level(level)
);

// File: tb/sim_tl_gate_sequencer.sv
module sim_tl_gate_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [23:0] period_len = 24'd60;
    logic [7:0]  dead_cnt = 8'd2;
    logic [11:0] gate;
    logic [5:0]  level;

    int checks = 0;
    int bad = 0;
    int interlock_hits = 0;
    bit started = 0;
    string cur = "R1";

    tl_gate_sequencer u0 (
        .clk(clk), .rst(rst), .en(en), .period_len(period_len),
        .dead_cnt(dead_cnt), .gate(gate), .level(level)
    );

    always #10 clk = ~clk;

    // behavioural reference
    int tick = 0, six = 0, seg = 10;
    logic [3:0] mg [3];
    int mdc [3];
    bit mb [3];

    function automatic logic [3:0] pat(input int s);
        if (s == 0 || s == 1) return 4'b0011;
        if (s == 3 || s == 4) return 4'b1100;
        return 4'b0110;
    endfunction

    function automatic logic [1:0] lvl(input logic [3:0] g);
        if (g == 4'b0011) return 2'b10;
        if (g == 4'b0110) return 2'b01;
        if (g == 4'b1100) return 2'b00;
        return 2'b11;
    endfunction

    function automatic int seglen(input int per);
        int q;
        q = per / 6;
        return (q == 0) ? 1 : q;
    endfunction

    initial for (int p = 0; p < 3; p++) begin mg[p] = 4'b0; mdc[p] = 0; mb[p] = 0; end

    always @(posedge clk) begin
        started <= 1;
        if (rst || !en) begin
            tick = 0; six = 0; seg = seglen(int'(period_len));
            for (int p = 0; p < 3; p++) begin mg[p] = 4'b0; mb[p] = 0; mdc[p] = 0; end
        end else begin
            for (int p = 0; p < 3; p++) begin
                logic [3:0] t;
                t = pat((six + 18 - 2 * p) % 6);
                if (mb[p]) begin
                    if (mdc[p] <= 1) begin mg[p] = t; mb[p] = 0; end
                    else mdc[p] = mdc[p] - 1;
                end else if (mg[p] != t) begin
                    if (dead_cnt == 0) mg[p] = t;
                    else begin mg[p] = mg[p] & t; mb[p] = 1; mdc[p] = int'(dead_cnt); end
                end
            end
            if (tick == seg - 1) begin
                tick = 0;
                if (six == 5) begin six = 0; seg = seglen(int'(period_len)); end
                else six = six + 1;
            end else tick = tick + 1;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic [11:0] eg;
            logic [5:0]  el;
            eg = {mg[2], mg[1], mg[0]};
            el = {lvl(mg[2]), lvl(mg[1]), lvl(mg[0])};
            checks++;
            if (gate !== eg || level !== el) begin
                bad++;
                $display("FAIL %s t=%0t gate=%h exp=%h level=%b exp=%b", cur, $time, gate, eg, level, el);
            end
            for (int p = 0; p < 3; p++)
                if ((gate[4*p] && gate[4*p+2]) || (gate[4*p+1] && gate[4*p+3]) || (gate[4*p] && gate[4*p+3]))
                    interlock_hits++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_changes(input int n, output int cnt);
        logic [1:0] last;
        last = level[1:0];
        cnt = 0;
        repeat (n) begin
            @(negedge clk);
            if (level[1:0] != 2'b11 && level[1:0] != last) begin
                cnt++;
                last = level[1:0];
            end
        end
    endtask

    initial begin
        int n;
        run(3);
        cur = "R1";
        chk("R1 gates in reset", int'(gate), 0);
        chk("R1 level in reset", int'(level), 63);
        rst = 1'b0;
        run(2);
        chk("R1 gates while disabled", int'(gate), 0);

        cur = "R2"; en = 1'b1;
        run(200);
        cur = "R8";
        count_changes(60, n);
        chk("R8 level changes per period", n, 4);

        cur = "R1"; en = 1'b0;
        run(1);
        chk("R1 gates after disable", int'(gate), 0);
        chk("R1 level after disable", int'(level), 63);

        cur = "R4"; dead_cnt = 8'd0; en = 1'b1;
        run(1);
        chk("R4 start-up levels", int'(level), 6'b010010);
        cur = "R6"; run(150);

        cur = "R3"; en = 1'b0; period_len = 24'd65; dead_cnt = 8'd3;
        run(1); en = 1'b1;
        run(47);
        cur = "R5"; period_len = 24'd90;
        run(250);
        cur = "R7"; run(50);

        cur = "R3"; en = 1'b0; period_len = 24'd3; dead_cnt = 8'd0;
        run(1); en = 1'b1;
        run(40);
        cur = "R6"; en = 1'b0; period_len = 24'd12; dead_cnt = 8'd1;
        run(1); en = 1'b1;
        run(60);

        chk("R9 interlock violations", interlock_hits, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++; bad++;
        $display("FAIL watchdog expired in %s", cur);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule